// File: doc/BRIEF.md
# PLL Reconfiguration Sequencer

This block sits between software and an analog PLL macro and changes the PLL's divider settings without ever passing an unstable clock downstream. Software talks to it through one 32-bit control/status word: a write carries a two-bit command plus the divider fields, and a read returns the live PLL controls, the two lock indications and the sequencer's busy and error flags.

A rate-change command selects one of two paths. If the new feedback divider differs from the one in force, the output is switched to the reference, the PLL is held in reset while both dividers are loaded, reset is released, and the block waits for the early lock and then the late lock before it enables the output and removes the bypass. If the feedback divider is unchanged, only the output divider is updated, under bypass, with no reset and no lock wait. Separate commands release reset and wait for lock (prepare), assert reset (unprepare) and set or clear the output enable. Every phase holds its outputs for a parameterized minimum number of cycles. A lock wait that runs past a parameterized limit raises a sticky error and leaves the output in bypass. A combinational output gives the effective output rate for a given reference rate.

Top module: `pll_seq_ctrl`

## Requirements
- R1: After reset the read word shows busy 0, error 0, feedback divider RST_FB, output divider RST_Q, reference divider 0, range 0, internal bypass 0, PLL reset 1, external bypass 1, enable 0.
- R2: The read word places busy at bit 31, error at bit 30, late lock at bit 29, early lock at bit 28, feedback divider at 27:20, output divider at 18:16, reference divider at 12:8, range at 6:4, internal bypass at bit 3, PLL reset at bit 2, external bypass at bit 1, enable at bit 0; a write uses the same field positions and bits 31:30 as command (0 rate change, 1 prepare, 2 unprepare, 3 enable). A sequence ends only after the early lock and then the late lock have been seen, and busy falls one cycle after the late lock rises.
- R3: A rate change with a new feedback divider raises external bypass, then raises PLL reset, then loads both dividers while reset is high, then drops reset, waits for both locks, and ends with enable 1 and external bypass 0.
- R4: A rate change with an unchanged feedback divider raises external bypass, updates the output divider while bypass is high, then drops bypass; PLL reset never rises and busy lasts exactly 2×HOLD_CYC cycles.
- R5: Prepare drops PLL reset and stays busy until both locks are seen; unprepare raises PLL reset on the next cycle without going busy and leaves every other control field unchanged.
- R6: The enable command copies write bit 0 to the enable output and changes no other field, whatever the other write bits hold.
- R7: While busy, every write is ignored: the reference divider, range, internal bypass, reset and enable fields keep the values the running sequence gives them.
- R8: If the locks are not both seen within LOCK_TMO cycles of the lock wait, the error bit sets, external bypass is 1 and busy drops; the error bit stays set until the next relock or prepare command is accepted, which clears it.
- R9: In the relock path, PLL reset rises exactly HOLD_CYC cycles after external bypass rises, the dividers change HOLD_CYC cycles after that, and reset falls HOLD_CYC cycles after the dividers change.
- R10: The rate output equals the reference rate when external bypass is 1, and otherwise equals floor(reference × (feedback divider + 1) / 2^output divider).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Write strobe for the control word |
| csr_wdata | input | 32 | Write data: command in 31:30 and divider fields |
| csr_rdata | output | 32 | Status and control readback |
| pll_lock | input | 1 | Early lock indication from the PLL |
| pll_lock_late | input | 1 | Late lock indication from the PLL |
| ref_rate | input | REF_W | Reference rate used by the rate calculation |
| pll_ext_bypass | output | 1 | Route the reference to the output |
| pll_reset | output | 1 | PLL reset |
| pll_ext_enable | output | 1 | Output enable |
| pll_int_bypass | output | 1 | PLL internal bypass control |
| pll_fbdiv | output | 8 | Feedback divider |
| pll_outdiv | output | 3 | Output divider (power-of-two exponent) |
| pll_refdiv | output | 5 | Reference divider |
| pll_range | output | 3 | Loop filter range select |
| out_rate | output | REF_W+8 | Effective output rate |

## Verification
The assertions assume the PLL drops both lock indications while its reset is high and raises the early lock no later than the late lock, so that a late lock seen by the sequencer always follows an early one. The bench's lock stub keeps within this: it counts cycles since reset was released, asserts the early lock after a shorter count than the late one, and clears both on reset; a separate switch holds the stub unlocked to reach the timeout. Writes during busy are issued deliberately, and every other command is issued only when busy is low.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    localparam int CSR_W = 32;
    localparam int FB_W  = 8;
    localparam int Q_W   = 3;
    localparam int RD_W  = 5;
    localparam int RG_W  = 3;

    // field positions shared by read and write words
    localparam int BUSY_BIT  = 31;
    localparam int ERR_BIT   = 30;
    localparam int LOCKB_BIT = 29;
    localparam int LOCKA_BIT = 28;
    localparam int FB_LSB    = 20;
    localparam int Q_LSB     = 16;
    localparam int RD_LSB    = 8;
    localparam int RG_LSB    = 4;
    localparam int IBYP_BIT  = 3;
    localparam int RST_BIT   = 2;
    localparam int XBYP_BIT  = 1;
    localparam int EN_BIT    = 0;
    localparam int OP_LSB    = 30;

    typedef enum logic [1:0] {
        OP_RATE   = 2'd0,
        OP_PREP   = 2'd1,
        OP_UNPREP = 2'd2,
        OP_ENA    = 2'd3
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_BYP, S_RST, S_LOAD, S_REL,
        S_WLA, S_WLB, S_QBYP, S_QLOAD, S_PREL
    } state_e;

    typedef struct packed {
        logic [FB_W-1:0] fb;
        logic [Q_W-1:0]  q;
        logic [RD_W-1:0] refdiv;
        logic [RG_W-1:0] rng;
        logic            int_byp;
        logic            rst;
        logic            ext_byp;
        logic            en;
    } ctl_t;

    function automatic ctl_t unpack_req(input logic [CSR_W-1:0] w);
        ctl_t c;
        c.fb      = w[FB_LSB +: FB_W];
        c.q       = w[Q_LSB  +: Q_W];
        c.refdiv  = w[RD_LSB +: RD_W];
        c.rng     = w[RG_LSB +: RG_W];
        c.int_byp = w[IBYP_BIT];
        c.rst     = w[RST_BIT];
        c.ext_byp = w[XBYP_BIT];
        c.en      = w[EN_BIT];
        return c;
    endfunction

    function automatic logic [CSR_W-1:0] pack_status(input ctl_t c, input logic busy,
                                                     input logic err, input logic la,
                                                     input logic lb);
        logic [CSR_W-1:0] r;
        r                    = '0;
        r[BUSY_BIT]          = busy;
        r[ERR_BIT]           = err;
        r[LOCKB_BIT]         = lb;
        r[LOCKA_BIT]         = la;
        r[FB_LSB +: FB_W]    = c.fb;
        r[Q_LSB  +: Q_W]     = c.q;
        r[RD_LSB +: RD_W]    = c.refdiv;
        r[RG_LSB +: RG_W]    = c.rng;
        r[IBYP_BIT]          = c.int_byp;
        r[RST_BIT]           = c.rst;
        r[XBYP_BIT]          = c.ext_byp;
        r[EN_BIT]            = c.en;
        return r;
    endfunction

    function automatic logic is_hold(input state_e s);
        return (s == S_BYP) || (s == S_RST) || (s == S_LOAD) || (s == S_REL) ||
               (s == S_QBYP) || (s == S_QLOAD) || (s == S_PREL);
    endfunction

    function automatic logic is_wait(input state_e s);
        return (s == S_WLA) || (s == S_WLB);
    endfunction

endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic done
);
    localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (run && cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && (cnt == LAST);

endmodule

// File: rtl/pll_seq_rate.sv
module pll_seq_rate
    import pll_seq_pkg::*;
#(
    parameter int REF_W = 16
) (
    input  logic [REF_W-1:0]      ref_rate,
    input  logic                  bypass,
    input  logic [FB_W-1:0]       fb,
    input  logic [Q_W-1:0]        q,
    output logic [REF_W+FB_W-1:0] rate
);
    localparam int PW = REF_W + FB_W + 1;

    logic [PW-1:0] mult;
    logic [PW-1:0] prod;
    logic [PW-1:0] shifted;

    always_comb begin
        mult    = PW'(fb) + PW'(1);
        prod    = PW'(ref_rate) * mult;
        shifted = prod >> q;
        rate    = bypass ? (REF_W+FB_W)'(ref_rate) : shifted[REF_W+FB_W-1:0];
    end

endmodule

// File: rtl/pll_seq_core.sv
module pll_seq_core
    import pll_seq_pkg::*;
#(
    parameter logic [FB_W-1:0] RST_FB = 8'd31,
    parameter logic [Q_W-1:0]  RST_Q  = 3'd1
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   cmd_valid,
    input  op_e    cmd_op,
    input  ctl_t   req,
    input  logic   lock_a,
    input  logic   lock_b,
    input  logic   hold_done,
    input  logic   tmo_done,
    output ctl_t   ctl,
    output logic   busy,
    output logic   err,
    output logic   in_hold,
    output logic   in_wait
);
    state_e          state;
    logic [FB_W-1:0] pend_fb;
    logic [Q_W-1:0]  pend_q;
    logic            relock;
    logic            accept;

    assign busy    = (state != S_IDLE);
    assign accept  = cmd_valid && !busy;
    assign in_hold = is_hold(state);
    assign in_wait = is_wait(state);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= S_IDLE;
            ctl.fb      <= RST_FB;
            ctl.q       <= RST_Q;
            ctl.refdiv  <= '0;
            ctl.rng     <= '0;
            ctl.int_byp <= 1'b0;
            ctl.rst     <= 1'b1;
            ctl.ext_byp <= 1'b1;
            ctl.en      <= 1'b0;
            pend_fb     <= RST_FB;
            pend_q      <= RST_Q;
            relock      <= 1'b0;
            err         <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (accept) begin
                        case (cmd_op)
                            OP_RATE: begin
                                ctl.refdiv  <= req.refdiv;
                                ctl.rng     <= req.rng;
                                ctl.int_byp <= req.int_byp;
                                ctl.ext_byp <= 1'b1;
                                pend_fb     <= req.fb;
                                pend_q      <= req.q;
                                if (req.fb != ctl.fb) begin
                                    relock <= 1'b1;
                                    err    <= 1'b0;
                                    state  <= S_BYP;
                                end else begin
                                    state  <= S_QBYP;
                                end
                            end
                            OP_PREP: begin
                                ctl.rst <= 1'b0;
                                relock  <= 1'b0;
                                err     <= 1'b0;
                                state   <= S_PREL;
                            end
                            OP_UNPREP: ctl.rst <= 1'b1;
                            default:   ctl.en  <= req.en;
                        endcase
                    end
                end
                S_BYP: if (hold_done) begin
                    ctl.rst <= 1'b1;
                    state   <= S_RST;
                end
                S_RST: if (hold_done) begin
                    ctl.fb <= pend_fb;
                    ctl.q  <= pend_q;
                    state  <= S_LOAD;
                end
                S_LOAD: if (hold_done) begin
                    ctl.rst <= 1'b0;
                    state   <= S_REL;
                end
                S_REL, S_PREL: if (hold_done) state <= S_WLA;
                S_WLA: begin
                    if (lock_a) begin
                        state <= S_WLB;
                    end else if (tmo_done) begin
                        err         <= 1'b1;
                        ctl.ext_byp <= 1'b1;
                        state       <= S_IDLE;
                    end
                end
                S_WLB: begin
                    if (lock_b) begin
                        if (relock) begin
                            ctl.en      <= 1'b1;
                            ctl.ext_byp <= 1'b0;
                        end
                        state <= S_IDLE;
                    end else if (tmo_done) begin
                        err         <= 1'b1;
                        ctl.ext_byp <= 1'b1;
                        state       <= S_IDLE;
                    end
                end
                S_QBYP: if (hold_done) begin
                    ctl.q <= pend_q;
                    state <= S_QLOAD;
                end
                S_QLOAD: if (hold_done) begin
                    ctl.ext_byp <= 1'b0;
                    state       <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
    import pll_seq_pkg::*;
#(
    parameter int              HOLD_CYC = 4,
    parameter int              LOCK_TMO = 64,
    parameter int              REF_W    = 16,
    parameter logic [FB_W-1:0] RST_FB   = 8'd31,
    parameter logic [Q_W-1:0]  RST_Q    = 3'd1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  csr_wr,
    input  logic [31:0]           csr_wdata,
    output logic [31:0]           csr_rdata,
    input  logic                  pll_lock,
    input  logic                  pll_lock_late,
    input  logic [REF_W-1:0]      ref_rate,
    output logic                  pll_ext_bypass,
    output logic                  pll_reset,
    output logic                  pll_ext_enable,
    output logic                  pll_int_bypass,
    output logic [7:0]            pll_fbdiv,
    output logic [2:0]            pll_outdiv,
    output logic [4:0]            pll_refdiv,
    output logic [2:0]            pll_range,
    output logic [REF_W+7:0]      out_rate
);
    ctl_t ctl;
    ctl_t req;
    op_e  op;
    logic busy, err, in_hold, in_wait, hold_done, tmo_done;

    assign req = unpack_req(csr_wdata);
    assign op  = op_e'(csr_wdata[OP_LSB +: 2]);

    pll_seq_timer #(.LIMIT(HOLD_CYC)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .clear(!in_hold || hold_done),
        .run  (in_hold),
        .done (hold_done)
    );

    pll_seq_timer #(.LIMIT(LOCK_TMO)) u_tmo (
        .clk  (clk),
        .rst  (rst),
        .clear(!in_wait),
        .run  (in_wait),
        .done (tmo_done)
    );

    pll_seq_core #(.RST_FB(RST_FB), .RST_Q(RST_Q)) u_core (
        .clk      (clk),
        .rst      (rst),
        .cmd_valid(csr_wr),
        .cmd_op   (op),
        .req      (req),
        .lock_a   (pll_lock),
        .lock_b   (pll_lock_late),
        .hold_done(hold_done),
        .tmo_done (tmo_done),
        .ctl      (ctl),
        .busy     (busy),
        .err      (err),
        .in_hold  (in_hold),
        .in_wait  (in_wait)
    );

    pll_seq_rate #(.REF_W(REF_W)) u_rate (
        .ref_rate(ref_rate),
        .bypass  (ctl.ext_byp),
        .fb      (ctl.fb),
        .q       (ctl.q),
        .rate    (out_rate)
    );

    assign csr_rdata      = pack_status(ctl, busy, err, pll_lock, pll_lock_late);
    assign pll_ext_bypass = ctl.ext_byp;
    assign pll_reset      = ctl.rst;
    assign pll_ext_enable = ctl.en;
    assign pll_int_bypass = ctl.int_byp;
    assign pll_fbdiv      = ctl.fb;
    assign pll_outdiv     = ctl.q;
    assign pll_refdiv     = ctl.refdiv;
    assign pll_range      = ctl.rng;

endmodule

// File: rtl/pll_seq_ctrl_chk.sv
module pll_seq_ctrl_chk #(
    parameter int REF_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             csr_wr,
    input logic [31:0]      csr_wdata,
    input logic [31:0]      csr_rdata,
    input logic             pll_lock_late,
    input logic [REF_W-1:0] ref_rate,
    input logic             pll_ext_bypass,
    input logic             pll_reset,
    input logic             pll_ext_enable,
    input logic [7:0]       pll_fbdiv,
    input logic [2:0]       pll_outdiv,
    input logic [4:0]       pll_refdiv,
    input logic [REF_W+7:0] out_rate
);
    logic busy, err;
    assign busy = csr_rdata[31];
    assign err  = csr_rdata[30];

    p_fb_load_in_reset_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(pll_fbdiv) |-> (pll_reset && pll_ext_bypass));

    p_outdiv_under_bypass_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(pll_outdiv) |-> pll_ext_bypass);

    p_enable_after_late_lock_r2: assert property (@(posedge clk) disable iff (rst)
        ($rose(pll_ext_enable) && $past(busy)) |-> $past(pll_lock_late));

    p_error_clears_on_start_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(err) |-> busy);

    p_busy_keeps_enable_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && csr_wr && csr_wdata[31:30] == 2'b11 && !csr_wdata[0] && pll_ext_enable)
        |=> pll_ext_enable);

    p_busy_keeps_refdiv_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && csr_wr) |=> $stable(pll_refdiv));

    p_bypass_rate_r10: assert property (@(posedge clk) disable iff (rst)
        pll_ext_bypass |-> (out_rate == (REF_W+8)'(ref_rate)));

endmodule

bind pll_seq_ctrl pll_seq_ctrl_chk #(.REF_W(REF_W)) u_chk (.*);

// File: tb/pll_seq_ctrl_tb.sv
module pll_seq_ctrl_tb;

    localparam int HOLD  = 3;
    localparam int TMO   = 60;
    localparam int REFW  = 16;
    localparam int LA    = 8;
    localparam int LB    = 14;
    localparam int WDOG  = 150000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             csr_wr = 1'b0;
    logic [31:0]      csr_wdata = '0;
    logic [31:0]      csr_rdata;
    logic             lock_a, lock_b;
    logic [REFW-1:0]  ref_rate = 16'd100;
    logic             byp, prst, en, ibyp;
    logic [7:0]       fb;
    logic [2:0]       q;
    logic [4:0]       rdiv;
    logic [2:0]       rng;
    logic [REFW+7:0]  out_rate;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pll_seq_ctrl #(.HOLD_CYC(HOLD), .LOCK_TMO(TMO), .REF_W(REFW),
                   .RST_FB(8'd31), .RST_Q(3'd1)) u_dut (
        .clk(clk), .rst(rst), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .pll_lock(lock_a), .pll_lock_late(lock_b),
        .ref_rate(ref_rate), .pll_ext_bypass(byp), .pll_reset(prst),
        .pll_ext_enable(en), .pll_int_bypass(ibyp), .pll_fbdiv(fb),
        .pll_outdiv(q), .pll_refdiv(rdiv), .pll_range(rng), .out_rate(out_rate));

    // lock stub
    logic [7:0] lcnt;
    bit dead = 0;
    always_ff @(posedge clk) begin
        if (rst || prst || dead) lcnt <= '0;
        else if (lcnt != 8'hFF) lcnt <= lcnt + 1'b1;
    end
    assign lock_a = (lcnt >= LA);
    assign lock_b = (lcnt >= LB);

    // event monitor
    int cyc = 0;
    int t_byp_rise, t_byp_fall, t_rst_rise, t_rst_fall, t_fb_chg;
    int t_lb_rise, t_busy_rise, t_busy_fall, n_rst_rise = 0;
    logic p_byp = 0, p_rst = 0, p_lb = 0, p_busy = 0;
    logic [7:0] p_fb = 0;
    always @(negedge clk) begin
        cyc++;
        if (byp && !p_byp) t_byp_rise = cyc;
        if (!byp && p_byp) t_byp_fall = cyc;
        if (prst && !p_rst) begin t_rst_rise = cyc; n_rst_rise++; end
        if (!prst && p_rst) t_rst_fall = cyc;
        if (fb != p_fb) t_fb_chg = cyc;
        if (lock_b && !p_lb) t_lb_rise = cyc;
        if (csr_rdata[31] && !p_busy) t_busy_rise = cyc;
        if (!csr_rdata[31] && p_busy) t_busy_fall = cyc;
        p_byp = byp; p_rst = prst; p_lb = lock_b; p_busy = csr_rdata[31]; p_fb = fb;
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(negedge clk) begin
        if (cyc > WDOG && !finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual %0d cycles, expected below %0d", cyc, WDOG);
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic csr_write(input logic [31:0] d);
        @(negedge clk);
        csr_wr = 1'b1; csr_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0; csr_wdata = '0;
        #1;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000; i++) begin
            if (!csr_rdata[31]) break;
            @(negedge clk); #1;
        end
    endtask

    function automatic logic [31:0] mk_rate(input logic [7:0] f, input logic [2:0] qq,
                                            input logic [4:0] rd, input logic [2:0] rg,
                                            input logic ib);
        return {2'b00, 2'b00, f, 1'b0, qq, 3'b000, rd, 1'b0, rg, ib, 3'b000};
    endfunction

    function automatic longint exp_rate(input longint r, input logic b,
                                        input int f, input int qq);
        if (b) return r;
        return (r * (f + 1)) >> qq;
    endfunction

    logic [31:0] snap;
    int nr;
    int ref_list [4] = '{1, 1000, 40000, 65535};

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 reset word", csr_rdata, (32'd31 << 20) | (32'd1 << 16) | 32'h6);
        chk("R1 R10 bypass rate at reset", out_rate, 100);

        // R10 sweep with R3/R4 paths
        for (int i = 0; i < 16; i++) begin
            int f;
            f = i * 17;
            csr_write(mk_rate(f[7:0], 3'd0, 5'd3, 3'd2, 1'b0));
            wait_idle();
            for (int qq = 0; qq < 8; qq++) begin
                csr_write(mk_rate(f[7:0], qq[2:0], 5'd3, 3'd2, 1'b0));
                wait_idle();
                chk("R2 R3 R4 readback", csr_rdata & 32'hCFFF_FFFF,
                    (longint'(f) << 20) | (longint'(qq) << 16) | (3 << 8) | (2 << 4) | 1);
                for (int k = 0; k < 4; k++) begin
                    ref_rate = ref_list[k][15:0];
                    #1;
                    chk("R10 rate", out_rate, exp_rate(ref_list[k], 1'b0, f, qq));
                end
            end
        end
        ref_rate = 16'd100;

        // R4 quick path timing, no reset pulse
        nr = n_rst_rise;
        csr_write(mk_rate(8'd255, 3'd2, 5'd3, 3'd2, 1'b0));
        chk("R4 bypass held during quick path", byp, 1);
        wait_idle();
        chk("R4 no reset pulse", n_rst_rise, nr);
        chk("R4 busy length", t_busy_fall - t_busy_rise, 2 * HOLD);
        chk("R4 bypass released", byp, 0);
        chk("R4 outdiv", q, 2);

        // R3 / R9 / R7 relock with writes during busy
        csr_write(mk_rate(8'd100, 3'd3, 5'd3, 3'd2, 1'b0));
        repeat (2) @(negedge clk);
        csr_write(mk_rate(8'd100, 3'd3, 5'd9, 3'd5, 1'b1));
        csr_write({2'b11, 30'h0});
        wait_idle();
        chk("R9 reset after bypass", t_rst_rise - t_byp_rise, HOLD);
        chk("R9 dividers after reset", t_fb_chg - t_rst_rise, HOLD);
        chk("R9 release after load", t_rst_fall - t_fb_chg, HOLD);
        chk("R3 bypass drop after late lock", t_byp_fall - t_lb_rise, 1);
        chk("R3 final controls", csr_rdata & 32'h0FFF_FFFF,
            (100 << 20) | (3 << 16) | (3 << 8) | (2 << 4) | 1);
        chk("R7 refdiv range ibyp enable kept", {rdiv, rng, ibyp, en}, {5'd3, 3'd2, 1'b0, 1'b1});

        // R6 enable command
        snap = csr_rdata;
        csr_write({2'b11, 29'h0ABC_DEF5, 1'b0});
        chk("R6 disable only bit0", csr_rdata, snap & ~32'h1);
        csr_write({2'b11, 29'h1555_5555, 1'b1});
        chk("R6 enable only bit0", csr_rdata, snap);

        // R5 unprepare / prepare
        snap = csr_rdata;
        csr_write({2'b10, 30'h0});
        chk("R5 unprepare", csr_rdata & 32'hCFFF_FFFF, (snap & 32'hCFFF_FFFF) | 32'h4);
        repeat (3) @(negedge clk);
        #1;
        chk("R5 locks drop under reset", csr_rdata[29:28], 0);
        csr_write({2'b01, 30'h0});
        chk("R5 prepare busy", csr_rdata[31], 1);
        chk("R5 prepare releases reset", prst, 0);
        wait_idle();
        chk("R2 R5 busy ends after late lock", t_busy_fall - t_lb_rise, 1);
        chk("R2 lock bits", csr_rdata[29:28], 2'b11);

        // R8 timeout
        dead = 1;
        csr_write(mk_rate(8'd50, 3'd1, 5'd3, 3'd2, 1'b0));
        wait_idle();
        chk("R8 error set", csr_rdata[30], 1);
        chk("R8 bypass on timeout", byp, 1);
        chk("R8 wait length", t_busy_fall - t_rst_fall, HOLD + TMO);
        chk("R10 bypass rate", out_rate, 100);
        repeat (5) @(negedge clk);
        #1;
        chk("R8 error sticky", csr_rdata[30], 1);
        dead = 0;
        csr_write({2'b01, 30'h0});
        chk("R8 error cleared on prepare", csr_rdata[31:30], 2'b10);
        wait_idle();
        chk("R8 prepare completes", csr_rdata[31:28], 4'b0011);

        if (!finished) begin
            finished = 1;
            summary();
            $finish;
        end
    end

endmodule